// File: doc/BRIEF.md
# Configurable Output Cell for a Sum-of-Products Logic Array

This block is one output cell of a sum-of-products programmable logic array. It receives the OR-sum that the array computes for this cell, an enable term, the two shared register controls (an asynchronous clear term and a synchronous set term), the clock, a two-bit configuration code and the value sensed on the cell's pin. From these it produces the pin data and the pin enable for a three-state driver, and a feedback bit that returns to the array.

The configuration code chooses between a registered output and a combinational one. It also chooses whether the output is inverted, and it chooses the feedback source. The register is cleared at power-up and by the asynchronous clear term. It is set to 1 by the synchronous set term. In a test mode the register can be loaded from the pin, so that a state machine can start from any state.

Top module: `macro_out_cell`

## Requirements
- R1: The configuration code `cfg` selects the mode. `cfg[1]=0` gives a registered output, so the pin data comes from the register. `cfg[1]=1` gives a combinational output, so the pin data comes from `sum_in`. `cfg[0]=1` passes the selected value through unchanged (active high). `cfg[0]=0` inverts it (active low).
- R2: When `sset_term` is 1, the register holds 1 after the next rising clock edge.
- R3: When `areset_term` is 1, the register is 0 immediately, with no clock edge needed. A registered active-high pin then reads 0.
- R4: When no control term is active, the register takes `sum_in` on each rising clock edge.
- R5: The register controls have a fixed priority. From highest to lowest: asynchronous clear, then preload, then synchronous set, then data capture.
- R6: While `preload_en` is 1, the register takes the value of `pin_in` on the rising clock edge.
- R7: `pin_oe` equals `oe_term`. While the output is disabled, `pin_out` is 0. In combinational mode the pin value still reaches the array through `fb_out`, so the pin can be used as an input.
- R8: In registered modes `fb_out` is the register value, whatever the polarity setting. In combinational modes `fb_out` is `pin_in`.
- R9: While `rst_n` is 0, the register is 0. An enabled registered active-low pin then reads 1, and an enabled registered active-high pin reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Power-up clear, active low, asynchronous |
| sum_in | input | 1 | OR-sum from the array for this cell |
| oe_term | input | 1 | Output-enable product term |
| areset_term | input | 1 | Shared asynchronous clear term |
| sset_term | input | 1 | Shared synchronous set term |
| cfg | input | 2 | Mode code: bit 1 combinational, bit 0 active high |
| preload_en | input | 1 | Test preload mode |
| pin_in | input | 1 | Value sensed on the pin |
| pin_out | output | 1 | Data to the three-state driver |
| pin_oe | output | 1 | Enable to the three-state driver |
| fb_out | output | 1 | Feedback bit to the array |

## Verification
The bench asserts the asynchronous clear in the middle of a clock period and checks the pin before the next edge. A design that waited for the clock would still show the old state there. The bench also drives the clear term and the set term together, and preload together with set. A design with the priorities swapped would end with a 1 where 0 is expected, or would ignore the pin value.

Feedback is checked in a registered active-low mode. A design that took the feedback after the inversion would return the complement. The power-up value is checked under both polarities, which exposes a clear that sets the pin level instead of the register.

// File: rtl/macro_out_cell.sv
module macro_out_cell (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sum_in,
  input  logic       oe_term,
  input  logic       areset_term,
  input  logic       sset_term,
  input  logic [1:0] cfg,
  input  logic       preload_en,
  input  logic       pin_in,
  output logic       pin_out,
  output logic       pin_oe,
  output logic       fb_out
);

  logic q;
  logic clr_n;
  logic comb_mode;
  logic act_high;
  logic sel_val;
  logic d_next;

  assign clr_n     = rst_n & ~areset_term;
  assign comb_mode = cfg[1];
  assign act_high  = cfg[0];

  always_comb begin
    if (preload_en)     d_next = pin_in;
    else if (sset_term) d_next = 1'b1;
    else                d_next = sum_in;
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= 1'b0;
    else        q <= d_next;
  end

  assign sel_val = comb_mode ? sum_in : q;
  assign pin_oe  = oe_term;
  assign pin_out = oe_term & (act_high ? sel_val : ~sel_val);
  assign fb_out  = comb_mode ? pin_in : q;

  // R3: clear term seen at an edge means the register was already 0
  a_r3_async_clear: assert property (@(posedge clk) disable iff (!rst_n)
    areset_term |-> (q == 1'b0));

  // R2, R5: set wins over capture
  a_r2_sync_set: assert property (@(posedge clk) disable iff (!rst_n)
    (sset_term && !preload_en && !areset_term) |=> (q || areset_term));

  // R4: plain capture of the sum
  a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!sset_term && !preload_en && !areset_term) |=> ((q == $past(sum_in)) || areset_term));

  // R6, R5: preload wins over set
  a_r6_preload: assert property (@(posedge clk) disable iff (!rst_n)
    (preload_en && !areset_term) |=> ((q == $past(pin_in)) || areset_term));

endmodule

// File: tb/macro_out_cell_bench.sv
module macro_out_cell_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sum_in, oe_term, areset_term, sset_term, preload_en, pin_in;
  logic [1:0] cfg;
  logic       pin_out, pin_oe, fb_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  macro_out_cell u_macro_out_cell (
    .clk(clk), .rst_n(rst_n), .sum_in(sum_in), .oe_term(oe_term),
    .areset_term(areset_term), .sset_term(sset_term), .cfg(cfg),
    .preload_en(preload_en), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle_inputs();
    sum_in = 0; oe_term = 1; areset_term = 0; sset_term = 0;
    preload_en = 0; pin_in = 0; cfg = 2'b01;
  endtask

  task automatic t_powerup();
    idle_inputs();
    rst_n = 0;
    cfg = 2'b00;
    #3;
    chk("R9 active-low reads high", pin_out, 1'b1);
    cfg = 2'b01;
    #1;
    chk("R9 active-high reads low", pin_out, 1'b0);
    chk("R8 feedback after clear", fb_out, 1'b0);
    tick();
    rst_n = 1;
    tick();
  endtask

  task automatic t_capture();
    idle_inputs();
    sum_in = 1;
    tick();
    chk("R4 capture 1", pin_out, 1'b1);
    cfg = 2'b00;
    #1;
    chk("R1 registered inverted", pin_out, 1'b0);
    chk("R8 feedback not inverted", fb_out, 1'b1);
    sum_in = 0;
    tick();
    chk("R4 capture 0", pin_out, 1'b1);
    chk("R8 feedback follows register", fb_out, 1'b0);
  endtask

  task automatic t_comb();
    idle_inputs();
    cfg = 2'b11; sum_in = 1;
    #1;
    chk("R1 comb active-high", pin_out, 1'b1);
    cfg = 2'b10;
    #1;
    chk("R1 comb active-low", pin_out, 1'b0);
    pin_in = 1;
    #1;
    chk("R8 pin feedback 1", fb_out, 1'b1);
    pin_in = 0;
    #1;
    chk("R8 pin feedback 0", fb_out, 1'b0);
    tick();
  endtask

  task automatic t_sset();
    idle_inputs();
    sset_term = 1;
    tick();
    chk("R2 set loads 1", pin_out, 1'b1);
    sset_term = 0;
    tick();
    chk("R4 capture after set", pin_out, 1'b0);
  endtask

  task automatic t_areset();
    idle_inputs();
    sum_in = 1;
    tick();
    chk("R4 capture before clear", pin_out, 1'b1);
    #1;
    areset_term = 1;
    #1;
    chk("R3 clear without edge", pin_out, 1'b0);
    sset_term = 1;
    tick();
    chk("R5 clear beats set", pin_out, 1'b0);
    areset_term = 0; sset_term = 0;
    tick();
  endtask

  task automatic t_preload();
    idle_inputs();
    preload_en = 1; pin_in = 1;
    tick();
    chk("R6 preload 1", pin_out, 1'b1);
    pin_in = 0; sset_term = 1;
    tick();
    chk("R5 preload beats set", pin_out, 1'b0);
    sset_term = 0; pin_in = 1; areset_term = 1;
    tick();
    chk("R5 clear beats preload", pin_out, 1'b0);
    idle_inputs();
    tick();
  endtask

  task automatic t_enable();
    idle_inputs();
    cfg = 2'b11; sum_in = 1; oe_term = 0; pin_in = 1;
    #1;
    chk("R7 enable low", pin_oe, 1'b0);
    chk("R7 disabled data", pin_out, 1'b0);
    chk("R7 pin used as input", fb_out, 1'b1);
    oe_term = 1;
    #1;
    chk("R7 enable high", pin_oe, 1'b1);
    chk("R7 enabled data", pin_out, 1'b1);
    tick();
  endtask

  initial begin
    t_powerup();
    t_capture();
    t_comb();
    t_sset();
    t_areset();
    t_preload();
    t_enable();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule